// File: doc/BRIEF.md
# Prescaled Dual-Compare Event Timer

One general-purpose timer channel. It runs from a slow reference (nominally 32.768 kHz), which reaches the block as a one-cycle pulse `ref_tick` in the system clock domain. A power-of-two prescaler divides the reference by 2^scale, with scale from 0 to 8, so the divisor is 1 to 256. Each prescaled tick advances a 16-bit up-counter. When the count reaches 0xFFFF it rolls over to zero and keeps running. On each tick the count is compared against two compare registers. A match latches a sticky status flag, and the flag can drive an event output toward an external interrupt router.

Software uses a small word-wide register port. The port writes the two compare values, the counter and a setup word, and it reads all four back. The setup word holds the following:
- the prescale exponent
- a counter-enable bit
- an event-mode field per compare
- the two sticky flags
- a "claimed" flag

The first setup write after reset sets the claimed flag. From then on the configuration fields are frozen, so a second owner cannot change the channel's rate or event routing. Software can still start and stop the counter and acknowledge events.

Typical use as a tick source:
1. Load a compare value, clear the counter and enable counting.
2. On each event, write the setup word with enable low and the flag bits high. This stops the counter and clears the flags.
3. Reload the counter and re-enable.

Compare values from 0x000F to 0xFFFE are the usable range.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset:
  - the counter reads 0x0000.
  - both compare registers read 0xFFFF.
  - the setup word reads 0x0000.
  - both event outputs are low.
- R2: Setup bits 3:0 hold the prescale exponent. The counter advances once per 2^scale `ref_tick` pulses. A written exponent above 8 is stored and read back as 8.
- R3: Setup bit 15 is the counter enable. While it is 0, `ref_tick` pulses leave the counter unchanged.
- R4: A write to address 2 loads the counter with the written value and restarts the prescaler phase. After writing 0, the next increment comes only after a full 2^scale pulses.
- R5: On a prescaled tick where the counter equals compare register n, flag n is set on that same clock. Flag CMP1 is setup bit 12 and flag CMP2 is setup bit 13. Counting continues past the match.
- R6: The flags are sticky. A setup write with bit 15 = 0 clears each flag whose bit is written as 1. A setup write with bit 15 = 1 clears no flag. If a match and a clear land on the same clock, the match wins.
- R7: Each compare has an event-mode field: bits 7:6 for CMP1 and bits 9:8 for CMP2. The event output `evt_cmp1` or `evt_cmp2` is high while that flag is set and its mode field equals 3. Any other mode value keeps that output low.
- R8: Setup bit 11 (claimed) is read-only.
  - The first setup write after reset sets it, and only reset clears it.
  - While it is set, setup writes leave the scale and mode fields unchanged.
  - While it is set, setup writes still update the enable bit and still clear flags.
- R9: A tick at count 0xFFFF gives count 0x0000, and counting then proceeds.
- R10: The address map is:
  - 0: CMP1
  - 1: CMP2
  - 2: counter
  - 3: setup

  `rdata` is registered. It shows the register selected by `addr` one clock after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| evt_cmp1 | output | 1 | CMP1 event toward interrupt router |
| evt_cmp2 | output | 1 | CMP2 event toward interrupt router |

## Verification
Directed scenarios target the following corner cases:
- **Prescaler phase after a counter write.** A design that kept the old phase would increment early.
- **Scale clamp at 8.** A missing clamp reads back 12.
- **Match timing.** The flag must appear on the tick that leaves the compare value, not one later, and counting must continue past the match.
- **Flag clear with enable set.** Such a write must not clear a flag. A design that ignored the enable qualifier would drop pending events.
- **Modes other than 3.** These must keep the event output low even though the flag is set.
- **Claim lock.** A design that kept the scale and mode fields writable would let a second owner retune the channel. A design that also locked the enable would make the channel impossible to stop.
- **Rollover from 0xFFFF.** A saturating design would stick at the top of the count.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // setup word bit positions (software-visible layout)
  localparam int BIT_EN    = 15;
  localparam int BIT_FLG2  = 13;
  localparam int BIT_FLG1  = 12;
  localparam int BIT_CLAIM = 11;
  localparam int MODE2_LO  = 8;
  localparam int MODE1_LO  = 6;
  localparam int NUM_CMP   = 2;

  localparam logic [1:0] MODE_FIRE = 2'b11;

  typedef enum logic [1:0] {
    REG_CMP1  = 2'd0,
    REG_CMP2  = 2'd1,
    REG_COUNT = 2'd2,
    REG_SETUP = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int MAX_SCALE = 8,
  localparam int SW = $clog2(MAX_SCALE + 1),
  localparam int PW = (MAX_SCALE < 1) ? 1 : MAX_SCALE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          run,
  input  logic          restart,
  input  logic [SW-1:0] scale,
  output logic          tick
);
  logic [PW-1:0] phase;
  logic [PW:0]   span;

  // span low bits = 2^scale - 1 : terminal phase value
  always_comb span = ({{PW{1'b0}}, 1'b1} << scale) - {{PW{1'b0}}, 1'b1};

  assign tick = run && ref_tick && (phase == span[PW-1:0]);

  always_ff @(posedge clk) begin
    if (rst || restart)
      phase <= '0;
    else if (run && ref_tick)
      phase <= tick ? '0 : phase + 1'b1;
  end

  // R3: no prescaled tick while counting is disabled
  assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
    tick |-> run);
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + 1'b1;
  end

  // R9: rollover from all-ones to zero
  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && (count == '1)) |=> (count == '0));
endmodule

// File: rtl/dct_compare.sv
module dct_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] count,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          clr,
  input  logic [1:0]    mode,
  output logic [CW-1:0] cmp_val,
  output logic          flag,
  output logic          evt
);
  logic hit;
  assign hit = tick && (count == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)         cmp_val <= '1;
    else if (cmp_we) cmp_val <= cmp_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;   // match beats a simultaneous clear
    else if (clr) flag <= 1'b0;
  end

  assign evt = flag && (mode == dct_pkg::MODE_FIRE);

  // R5: a match latches the flag on the same clock
  assert_hit_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R6: flag is held unless a clear is requested
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R7: an event never appears without its flag
  assert_evt_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    evt |-> flag);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CW        = 16,
  parameter int MAX_SCALE = 8,
  localparam int SW       = $clog2(MAX_SCALE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          evt_cmp1,
  output logic          evt_cmp2
);
  import dct_pkg::*;

  localparam int NC = NUM_CMP;

  logic          en_q, claimed_q;
  logic [SW-1:0] scale_q, scale_wr;
  logic [1:0]    mode_q [NC];
  logic          wr_setup, wr_count;
  logic          tick;
  logic [CW-1:0] count;
  logic [CW-1:0] cmp_val [NC];
  logic          flag [NC];
  logic          evt  [NC];
  logic          clr  [NC];
  logic          cmp_we [NC];

  localparam int FLG_BIT [NC] = '{BIT_FLG1, BIT_FLG2};
  localparam int MODE_LO [NC] = '{MODE1_LO, MODE2_LO};

  assign wr_setup = wr_en && (addr == REG_SETUP);
  assign wr_count = wr_en && (addr == REG_COUNT);

  // exponent clamp
  always_comb begin
    if (wdata[3:0] > 4'(MAX_SCALE)) scale_wr = SW'(MAX_SCALE);
    else                            scale_wr = SW'(wdata[3:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      claimed_q <= 1'b0;
      scale_q   <= '0;
    end else if (wr_setup) begin
      en_q      <= wdata[BIT_EN];
      claimed_q <= 1'b1;
      if (!claimed_q) scale_q <= scale_wr;
    end
  end

  dct_prescaler #(.MAX_SCALE(MAX_SCALE)) u_pre (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .run(en_q),
    .restart(wr_count), .scale(scale_q), .tick(tick)
  );

  dct_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(wr_count),
    .load_val(wdata), .count(count)
  );

  for (genvar i = 0; i < NC; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)                         mode_q[i] <= 2'b00;
      else if (wr_setup && !claimed_q) mode_q[i] <= wdata[MODE_LO[i] +: 2];
    end
    assign cmp_we[i] = wr_en && (addr == 2'(i));
    assign clr[i]    = wr_setup && !wdata[BIT_EN] && wdata[FLG_BIT[i]];

    dct_compare #(.CW(CW)) u_cmp (
      .clk(clk), .rst(rst), .tick(tick), .count(count),
      .cmp_we(cmp_we[i]), .cmp_wdata(wdata), .clr(clr[i]),
      .mode(mode_q[i]), .cmp_val(cmp_val[i]), .flag(flag[i]), .evt(evt[i])
    );
  end

  assign evt_cmp1 = evt[0];
  assign evt_cmp2 = evt[1];

  logic [CW-1:0] setup_rd;
  always_comb begin
    setup_rd                  = '0;
    setup_rd[BIT_EN]          = en_q;
    setup_rd[BIT_FLG2]        = flag[1];
    setup_rd[BIT_FLG1]        = flag[0];
    setup_rd[BIT_CLAIM]       = claimed_q;
    setup_rd[MODE2_LO +: 2]   = mode_q[1];
    setup_rd[MODE1_LO +: 2]   = mode_q[0];
    setup_rd[SW-1:0]          = scale_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        REG_CMP1:  rdata <= cmp_val[0];
        REG_CMP2:  rdata <= cmp_val[1];
        REG_COUNT: rdata <= count;
        default:   rdata <= setup_rd;
      endcase
    end
  end

  // R8: claimed never drops outside reset
  assert_claim_held_R8: assert property (@(posedge clk) disable iff (rst)
    claimed_q |=> claimed_q);
  // R2: stored exponent within range
  assert_scale_max_R2: assert property (@(posedge clk) disable iff (rst)
    scale_q <= SW'(MAX_SCALE));
  // R3: counter frozen while disabled and not written
  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !wr_count) |=> $stable(count));
endmodule

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        evt_cmp1, evt_cmp2;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dual_cmp_timer uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_cmp1(evt_cmp1), .evt_cmp2(evt_cmp2)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; ref_tick = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(2'd0, v); check("R1 cmp1", v, 16'hFFFF);
    rd(2'd1, v); check("R1 cmp2", v, 16'hFFFF);
    rd(2'd2, v); check("R1 count / R10", v, 16'h0000);
    rd(2'd3, v); check("R1 setup", v, 16'h0000);
    check("R1 evts", {14'd0, evt_cmp2, evt_cmp1}, 16'h0);
  endtask

  task automatic t_rate();
    logic [15:0] v;
    do_reset();
    wr(2'd3, 16'h8002);            // scale 2, enabled
    pulse(12); rd(2'd2, v); check("R2 12 pulses /4", v, 16'd3);
    pulse(3);  rd(2'd2, v); check("R2 partial phase", v, 16'd3);
    pulse(1);  rd(2'd2, v); check("R2 4th pulse", v, 16'd4);
    do_reset();
    wr(2'd3, 16'h8000);            // scale 0
    pulse(5);  rd(2'd2, v); check("R2 scale0", v, 16'd5);
  endtask

  task automatic t_enable_load();
    logic [15:0] v;
    do_reset();
    wr(2'd3, 16'h0000);
    pulse(5);  rd(2'd2, v); check("R3 disabled hold", v, 16'd0);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); check("R4 load", v, 16'h1234);
    wr(2'd3, 16'h8000);
    pulse(2);  rd(2'd2, v); check("R3 enabled count", v, 16'h1236);
  endtask

  task automatic t_restart();
    logic [15:0] v;
    do_reset();
    wr(2'd3, 16'h8002);
    pulse(3);
    wr(2'd2, 16'h0000);
    pulse(3);  rd(2'd2, v); check("R4 phase restarted", v, 16'd0);
    pulse(1);  rd(2'd2, v); check("R4 first after restart", v, 16'd1);
  endtask

  task automatic t_match_clear();
    logic [15:0] v;
    do_reset();
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd5);
    wr(2'd3, 16'h8300);           // enabled, CMP2 mode 3, CMP1 mode 0
    pulse(3);  rd(2'd3, v); check("R5 no flag before match", v, 16'h8B00);
    pulse(1);  rd(2'd3, v); check("R5 flag1 on match", v, 16'h9B00);
    check("R7 evt1 low mode0", {15'd0, evt_cmp1}, 16'd0);
    pulse(2);  rd(2'd3, v); check("R5 flag2 on match", v, 16'hBB00);
    check("R7 evt2 high mode3", {15'd0, evt_cmp2}, 16'd1);
    rd(2'd2, v); check("R5 counting continues", v, 16'd6);
    wr(2'd3, 16'h9300);           // flag bits with enable set: no clear
    rd(2'd3, v); check("R6 no clear while enabled", v, 16'hBB00);
    wr(2'd3, 16'h1000);           // disable, clear flag1 only
    rd(2'd3, v); check("R6 clear flag1 only", v, 16'h2B00);
    check("R6 evt2 still high", {15'd0, evt_cmp2}, 16'd1);
    wr(2'd3, 16'h3000);
    rd(2'd3, v); check("R6 clear both", v, 16'h0B00);
    check("R7 evt2 low after clear", {15'd0, evt_cmp2}, 16'd0);
    pulse(3);  rd(2'd2, v); check("R3 stopped by clear write", v, 16'd6);
  endtask

  task automatic t_other_mode();
    logic [15:0] v;
    do_reset();
    wr(2'd1, 16'd1);
    wr(2'd3, 16'h8100);           // CMP2 mode 1
    pulse(2);  rd(2'd3, v); check("R7 flag2 set mode1", v, 16'hA900);
    check("R7 evt2 low mode1", {15'd0, evt_cmp2}, 16'd0);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    do_reset();
    wr(2'd2, 16'hFFFE);
    wr(2'd3, 16'h8000);
    pulse(1);  rd(2'd2, v); check("R9 at top", v, 16'hFFFF);
    pulse(1);  rd(2'd2, v); check("R9 rollover", v, 16'h0000);
    pulse(1);  rd(2'd2, v); check("R9 after rollover", v, 16'h0001);
  endtask

  task automatic t_claim();
    logic [15:0] v;
    do_reset();
    wr(2'd3, 16'h030C);           // scale 12 -> 8, CMP2 mode 3
    rd(2'd3, v); check("R2 clamp / R8 claimed", v, 16'h0B08);
    wr(2'd3, 16'h00C1);           // try to change scale and CMP1 mode
    rd(2'd3, v); check("R8 fields locked", v, 16'h0B08);
    wr(2'd3, 16'h8000);
    rd(2'd3, v); check("R8 enable still writable", v, 16'h8B08);
  endtask

  initial begin
    t_reset();
    t_rate();
    t_enable_load();
    t_restart();
    t_match_clear();
    t_other_mode();
    t_wrap();
    t_claim();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule